// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block is the arithmetic and logic core of a small 8-bit controller datapath. It is purely combinational. Each cycle the surrounding pipeline gives it two operands, the current carry and nibble-carry flags, and a 5-bit operation code. It returns the 8-bit result, the next values of four condition flags, and a write enable for each flag, so that the caller changes only the flags the operation defines.

The operations are binary add and subtract (each with or without the incoming carry), packed-decimal correction, bitwise AND, OR, XOR and complement, four rotations, increment and decrement, and four conditional-skip tests. Subtraction follows the "carry means no borrow" convention at both the byte and the nibble level. A skip output tells the sequencer to discard the next instruction.

When a flag's write enable is low, its output carries a fixed value. For carry and nibble-carry this is the incoming flag, and for zero and overflow it is 0. An enclosing register file can therefore load either the whole flag set or only the enabled flags. Instruction decode, register access and pipeline staging stay outside the block.

Top module: `alu8_status`

## Requirements
- R1: op 0 (ADD) gives a_i+b_i mod 256, and op 1 (ADC) gives a_i+b_i+c_i mod 256. For both, c_o is the carry out of bit 7 and c_we_o, ac_we_o, z_we_o and ov_we_o are all 1.
- R2: op 2 (SUB) gives a_i-b_i mod 256, and op 3 (SBC) gives a_i-b_i-(1-c_i) mod 256. For both, c_o is 1 exactly when no borrow occurs (a_i >= b_i plus the borrow-in), and all four write enables are 1.
- R3: For ops 0-3, ac_o is 1 on a carry out of bit 3 when adding. When subtracting it is 1 when the low nibble does not borrow from the high nibble.
- R4: For ops 0-3, ov_o is 1 exactly when the carry into bit 7 differs from the carry out of bit 7.
- R5: Whenever z_we_o is 1, z_o is 1 exactly when res_o is 00h.
- R6: Ops 5 (AND), 6 (OR), 7 (XOR) and 8 (CPL, result ~a_i) set z_we_o to 1 and leave c_we_o, ac_we_o and ov_we_o at 0.
- R7: Op 9 (rotate left) and op 10 (rotate right) move bit 7 and bit 0 directly into each other and write no flags.
- R8: Op 11 (rotate left through carry) and op 12 (rotate right through carry) shift c_i into the vacated bit and load the bit shifted out into c_o. Only c_we_o is 1.
- R9: Op 13 (INC) gives a_i+1 and op 14 (DEC) gives a_i-1, both wrapping mod 256. Only z_we_o is 1.
- R10: Op 4 (decimal correct) adds 06h when a_i[3:0] > 9 or ac_i is 1. It adds 60h when c_i is 1 or a_i > 99h. c_o is c_i OR (60h was added), and only c_we_o is 1.
- R11: Ops 15 (skip if a_i zero) and 16 (skip if a_i nonzero) return a_i. Ops 17 (increment, skip if result zero) and 18 (decrement, skip if result zero) return a_i+1 and a_i-1. skip_o follows the named test, and no flag is written.
- R12: With c_we_o low, c_o equals c_i. With ac_we_o low, ac_o equals ac_i. With z_we_o or ov_we_o low, that flag output is 0. Op codes 19-31 give res_o 00h, no write enable and no skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current nibble-carry flag |
| op_i | input | 5 | Operation code |
| res_o | output | 8 | Result byte |
| c_o | output | 1 | Next carry flag |
| ac_o | output | 1 | Next nibble-carry flag |
| z_o | output | 1 | Next zero flag |
| ov_o | output | 1 | Next overflow flag |
| c_we_o | output | 1 | Carry flag write enable |
| ac_we_o | output | 1 | Nibble-carry flag write enable |
| z_we_o | output | 1 | Zero flag write enable |
| ov_we_o | output | 1 | Overflow flag write enable |
| skip_o | output | 1 | Skip the next instruction |

## Verification
Directed operands come first. 7Fh+01h and 80h-01h separate the signed-overflow rule from plain carry. FFh+01h and equal-operand subtraction reach the zero result and the full carry chain. Operand pairs such as 10h-01h make the nibble flag and the byte flag take different values. For the decimal step and the skip tests, the vectors sit on the decision edges (nibble 9 against 10h, a_i at 99h against 9Ah, results that wrap through 00h), and both values of each incoming flag are applied. Every code, including the unused ones, is then swept with pseudo-random operands and flags, so that carry-in handling and the untouched-flag pass-through show up on patterns that the directed cases do not reach.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg
// Shared operation codes for the byte ALU. Codes 19..31 are unused and
// yield a zero result with no flag writes.
package alu8_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_DAA  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CPL  = 5'd8,
        OP_RL   = 5'd9,
        OP_RR   = 5'd10,
        OP_RLC  = 5'd11,
        OP_RRC  = 5'd12,
        OP_INC  = 5'd13,
        OP_DEC  = 5'd14,
        OP_SZ   = 5'd15,
        OP_SNZ  = 5'd16,
        OP_SIZ  = 5'd17,
        OP_SDZ  = 5'd18
    } alu_op_e;
endpackage

// File: rtl/alu8_adder.sv
// Module alu8_adder
// Ripple adder split at the nibble boundary and below the sign bit. It
// exposes the carry out of the low nibble, the carry into the top bit and
// the carry out of the top bit. Subtraction is done by the caller feeding
// the inverted operand and carry-in. Assumes W > NIB + 1.
module alu8_adder #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         nib_c_o,
    output logic         top_cin_o,
    output logic         cout_o
);
    localparam int MID = W - 1 - NIB;

    logic [NIB:0] lo;
    logic [MID:0] mid;
    logic [1:0]   hi;

    // Three-segment sum so that the intermediate carries are visible.
    always_comb begin
        lo  = {1'b0, x_i[NIB-1:0]} + {1'b0, y_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
        mid = {1'b0, x_i[W-2:NIB]} + {1'b0, y_i[W-2:NIB]} + {{MID{1'b0}}, lo[NIB]};
        hi  = {1'b0, x_i[W-1]} + {1'b0, y_i[W-1]} + {1'b0, mid[MID]};
    end

    assign sum_o     = {hi[0], mid[MID-1:0], lo[NIB-1:0]};
    assign nib_c_o   = lo[NIB];
    assign top_cin_o = mid[MID];
    assign cout_o    = hi[1];
endmodule

// File: rtl/alu8_bitops.sv
// Module alu8_bitops
// Bitwise operations and the four rotations. Also gives the bit that a
// rotation shifts out. Any code it does not handle yields zero.
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] res_o,
    output logic         out_bit_o
);
    // Select the bitwise or rotate result and the shifted-out bit.
    always_comb begin
        res_o     = '0;
        out_bit_o = 1'b0;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_CPL:  res_o = ~a_i;
            OP_RL:   res_o = {a_i[W-2:0], a_i[W-1]};
            OP_RR:   res_o = {a_i[0], a_i[W-1:1]};
            OP_RLC: begin
                res_o     = {a_i[W-2:0], c_i};
                out_bit_o = a_i[W-1];
            end
            OP_RRC: begin
                res_o     = {c_i, a_i[W-1:1]};
                out_bit_o = a_i[0];
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_decadj.sv
// Module alu8_decadj
// Works out the correction term for packed-decimal adjustment from the
// operand and the incoming carry flags. Assumes W >= 2*NIB. Bits above
// the second nibble stay zero.
module alu8_decadj #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    input  logic         ac_i,
    output logic [W-1:0] adj_o,
    output logic         hi_fix_o
);
    localparam logic [NIB-1:0] SIX  = NIB'(6);
    localparam logic [NIB-1:0] NINE = NIB'(9);

    logic lo_big;
    logic lo_fix;

    // Decide which nibbles need the +6 correction.
    always_comb begin
        lo_big   = a_i[NIB-1:0] > NINE;
        lo_fix   = lo_big | ac_i;
        hi_fix_o = c_i | (a_i[2*NIB-1:NIB] > NINE)
                 | ((a_i[2*NIB-1:NIB] == NINE) & lo_big);
        adj_o                  = '0;
        adj_o[NIB-1:0]         = lo_fix   ? SIX : '0;
        adj_o[2*NIB-1:NIB]     = hi_fix_o ? SIX : '0;
    end
endmodule

// File: rtl/alu8_status.sv
// Module alu8_status
// Combinational byte ALU top. It picks the adder operands for each code,
// merges the adder and bit-operation results, and forms the flag values,
// flag write enables and skip decision. Flags that are not written show
// the incoming value (C, AC) or zero (Z, OV). No clock or state.
module alu8_status
    import alu8_pkg::*;
#(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            c_i,
    input  logic            ac_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    res_o,
    output logic            c_o,
    output logic            ac_o,
    output logic            z_o,
    output logic            ov_o,
    output logic            c_we_o,
    output logic            ac_we_o,
    output logic            z_we_o,
    output logic            ov_we_o,
    output logic            skip_o
);
    alu_op_e     op;
    logic [W-1:0] add_y, add_sum, bit_res, adj;
    logic         add_ci, nib_c, top_cin, cout, out_bit, hi_fix;
    logic [W-1:0] res;
    logic         c_nx, ac_nx, ov_nx, res_zero, a_zero;

    assign op = alu_op_e'(op_i);

    // Pick the second adder operand and carry-in for each code.
    always_comb begin
        add_y  = '0;
        add_ci = 1'b0;
        unique case (op)
            OP_ADD:          add_y = b_i;
            OP_ADC: begin    add_y = b_i;  add_ci = c_i;  end
            OP_SUB: begin    add_y = ~b_i; add_ci = 1'b1; end
            OP_SBC: begin    add_y = ~b_i; add_ci = c_i;  end
            OP_DAA:          add_y = adj;
            OP_INC, OP_SIZ:  add_ci = 1'b1;
            OP_DEC, OP_SDZ:  add_y = '1;
            default:         add_y = '0;
        endcase
    end

    alu8_adder #(.W(W), .NIB(NIB)) u_add (
        .x_i       (a_i),
        .y_i       (add_y),
        .cin_i     (add_ci),
        .sum_o     (add_sum),
        .nib_c_o   (nib_c),
        .top_cin_o (top_cin),
        .cout_o    (cout)
    );

    alu8_bitops #(.W(W)) u_bit (
        .a_i       (a_i),
        .b_i       (b_i),
        .c_i       (c_i),
        .op_i      (op),
        .res_o     (bit_res),
        .out_bit_o (out_bit)
    );

    alu8_decadj #(.W(W), .NIB(NIB)) u_dadj (
        .a_i      (a_i),
        .c_i      (c_i),
        .ac_i     (ac_i),
        .adj_o    (adj),
        .hi_fix_o (hi_fix)
    );

    assign a_zero   = (a_i == '0);
    assign res_zero = (res == '0);

    // Merge results and decide which flags each code writes.
    always_comb begin
        res     = '0;
        c_nx    = c_i;
        ac_nx   = ac_i;
        ov_nx   = 1'b0;
        c_we_o  = 1'b0;
        ac_we_o = 1'b0;
        z_we_o  = 1'b0;
        ov_we_o = 1'b0;
        skip_o  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res     = add_sum;
                c_nx    = cout;
                ac_nx   = nib_c;
                ov_nx   = top_cin ^ cout;
                c_we_o  = 1'b1;
                ac_we_o = 1'b1;
                z_we_o  = 1'b1;
                ov_we_o = 1'b1;
            end
            OP_DAA: begin
                res    = add_sum;
                c_nx   = c_i | hi_fix;
                c_we_o = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                res    = bit_res;
                z_we_o = 1'b1;
            end
            OP_RL, OP_RR: res = bit_res;
            OP_RLC, OP_RRC: begin
                res    = bit_res;
                c_nx   = out_bit;
                c_we_o = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res    = add_sum;
                z_we_o = 1'b1;
            end
            OP_SZ: begin
                res    = a_i;
                skip_o = a_zero;
            end
            OP_SNZ: begin
                res    = a_i;
                skip_o = !a_zero;
            end
            OP_SIZ, OP_SDZ: begin
                res    = add_sum;
                skip_o = res_zero;
            end
            default: res = '0;
        endcase
    end

    // Drive outputs; unwritten Z and OV read as zero.
    assign res_o = res;
    assign c_o   = c_nx;
    assign ac_o  = ac_nx;
    assign ov_o  = ov_we_o & ov_nx;
    assign z_o   = z_we_o & res_zero;
endmodule

// File: rtl/alu8_status_chk.sv
// Module alu8_status_chk
// Port-level property checker for alu8_status, bound to every instance.
// The block is combinational, so the checks are immediate assertions on
// settled values.
module alu8_status_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0]    a_i,
    input logic [W-1:0]    b_i,
    input logic            c_i,
    input logic            ac_i,
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    res_o,
    input logic            c_o,
    input logic            ac_o,
    input logic            z_o,
    input logic            ov_o,
    input logic            c_we_o,
    input logic            ac_we_o,
    input logic            z_we_o,
    input logic            ov_we_o,
    input logic            skip_o
);
    logic [W:0] wide_sum;
    assign wide_sum = {1'b0, a_i} + {1'b0, b_i};

    // Check port relations for the current operation.
    always_comb begin
        if (op_i == OP_ADD)
            a_r1_add_sum: assert ({c_o, res_o} == wide_sum)
                else $error("R1 add sum/carry mismatch");
        if (op_i == OP_ADD)
            a_r4_add_sign_ov: assert (ov_o == ((a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1])))
                else $error("R4 overflow disagrees with sign rule");
        if (z_we_o)
            a_r5_zero_flag: assert (z_o == (res_o == '0))
                else $error("R5 zero flag wrong");
        if (op_i inside {OP_AND, OP_OR, OP_XOR, OP_CPL})
            a_r6_logic_z_only: assert (z_we_o && !c_we_o && !ac_we_o && !ov_we_o)
                else $error("R6 logic op wrote a non-zero flag");
        if (op_i inside {OP_RL, OP_RR})
            a_r7_rot_keeps_bits: assert ($countones(res_o) == $countones(a_i) && !c_we_o && !z_we_o)
                else $error("R7 plain rotate changed bit count or flags");
        if (op_i inside {OP_RLC, OP_RRC})
            a_r8_rot_carry_bits: assert (($countones(res_o) + int'(c_o)) == ($countones(a_i) + int'(c_i)))
                else $error("R8 carry rotate lost a bit");
        if (skip_o)
            a_r11_skip_source: assert (op_i inside {OP_SZ, OP_SNZ, OP_SIZ, OP_SDZ})
                else $error("R11 skip from a non-skip op");
        if (!c_we_o)
            a_r12_c_hold: assert (c_o == c_i)
                else $error("R12 carry changed without write");
        if (!ac_we_o)
            a_r12_ac_hold: assert (ac_o == ac_i)
                else $error("R12 nibble carry changed without write");
    end
endmodule

bind alu8_status alu8_status_chk #(.W(W)) u_status_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .ac_i    (ac_i),
    .op_i    (op_i),
    .res_o   (res_o),
    .c_o     (c_o),
    .ac_o    (ac_o),
    .z_o     (z_o),
    .ov_o    (ov_o),
    .c_we_o  (c_we_o),
    .ac_we_o (ac_we_o),
    .z_we_o  (z_we_o),
    .ov_we_o (ov_we_o),
    .skip_o  (skip_o)
);

// File: tb/test_alu8_status.sv
// Scoreboard bench for alu8_status. The driver applies a vector just after
// a rising edge and queues the expected outputs from a reference model.
// The monitor pops and compares on the falling edge.
module test_alu8_status;
    typedef struct packed {
        logic [7:0] res;
        logic c, ac, z, ov, cwe, acwe, zwe, owe, skip;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic       cin = 1'b0, acin = 1'b0;
    logic [4:0] op = 5'd31;
    logic [7:0] res;
    logic       c_o, ac_o, z_o, ov_o, c_we, ac_we, z_we, ov_we, skip;

    int    n_tests = 0;
    int    n_fail  = 0;
    exp_t  q_exp[$];
    string q_tag[$];
    bit    done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu8_status i_alu8_status (
        .a_i(a), .b_i(b), .c_i(cin), .ac_i(acin), .op_i(op),
        .res_o(res), .c_o(c_o), .ac_o(ac_o), .z_o(z_o), .ov_o(ov_o),
        .c_we_o(c_we), .ac_we_o(ac_we), .z_we_o(z_we), .ov_we_o(ov_we),
        .skip_o(skip)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input int o, input int x, input int y, input int ci, input int aci);
        exp_t e;
        int yy, cc, s;
        e = '0;
        e.c = ci[0]; e.ac = aci[0];
        if (o <= 3) begin
            yy = (o >= 2) ? (~y & 255) : y;
            cc = (o == 0) ? 0 : (o == 2) ? 1 : ci;
            s  = x + yy + cc;
            e.res = s[7:0];
            e.c   = s[8];
            e.ac  = (((x & 15) + (yy & 15) + cc) > 15);
            e.ov  = (x[7] == yy[7]) && (e.res[7] != x[7]);
            e.cwe = 1; e.acwe = 1; e.zwe = 1; e.owe = 1;
        end else if (o == 4) begin
            s = x;
            if ((x & 15) > 9 || aci != 0) s += 6;
            if (ci != 0 || x > 'h99) begin s += 'h60; e.c = 1; end
            e.res = s[7:0]; e.cwe = 1;
        end else if (o >= 5 && o <= 8) begin
            case (o)
                5: e.res = 8'(x & y);
                6: e.res = 8'(x | y);
                7: e.res = 8'(x ^ y);
                default: e.res = 8'(~x);
            endcase
            e.zwe = 1;
        end else if (o == 9)  e.res = 8'((x << 1) | (x >> 7));
        else if (o == 10)     e.res = 8'((x >> 1) | (x << 7));
        else if (o == 11) begin e.res = 8'((x << 1) | ci); e.c = x[7]; e.cwe = 1; end
        else if (o == 12) begin e.res = 8'((x >> 1) | (ci << 7)); e.c = x[0]; e.cwe = 1; end
        else if (o == 13 || o == 14) begin
            e.res = 8'((o == 13) ? x + 1 : x + 255); e.zwe = 1;
        end else if (o == 15 || o == 16) begin
            e.res = 8'(x); e.skip = (o == 15) ? (x == 0) : (x != 0);
        end else if (o == 17 || o == 18) begin
            e.res = 8'((o == 17) ? x + 1 : x + 255); e.skip = (e.res == 0);
        end
        if (e.zwe) e.z = (e.res == 0);
        return e;
    endfunction

    function automatic string tag_of(input int o);
        if (o <= 1) return "R1";
        if (o <= 3) return "R2";
        if (o == 4) return "R10";
        if (o <= 8) return "R6";
        if (o <= 10) return "R7";
        if (o <= 12) return "R8";
        if (o <= 14) return "R9";
        if (o <= 18) return "R11";
        return "R12";
    endfunction

    // Driver: apply one vector and queue its expected outputs.
    task automatic drive(input int o, input int x, input int y, input int ci, input int aci, input string t);
        @(posedge clk);
        op = 5'(o); a = 8'(x); b = 8'(y); cin = ci[0]; acin = aci[0];
        q_exp.push_back(model(o, x, y, ci, aci));
        q_tag.push_back(t);
    endtask

    // Monitor: compare the settled outputs against the queue head.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            exp_t e, g;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            g = '{res, c_o, ac_o, z_o, ov_o, c_we, ac_we, z_we, ov_we, skip};
            n_tests++;
            if (g !== e) begin
                n_fail++;
                $display("FAIL %s op=%0d a=%h b=%h c=%0d ac=%0d actual=%h expected=%h",
                         t, op, a, b, cin, acin, g, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state after reset: unused code, all-zero inputs (R12).
        drive(31, 0, 0, 0, 0, "R12 reset idle");
        // R1 add carry, R4 overflow, R3 nibble carry, R5 zero.
        drive(0, 'h7F, 'h01, 0, 0, "R4 R3 add overflow");
        drive(0, 'hFF, 'h01, 0, 0, "R1 R5 add wrap to zero");
        drive(1, 'h10, 'h20, 1, 0, "R1 adc carry in");
        // R2 subtract, R3 nibble borrow, R4 overflow.
        drive(2, 'h05, 'h03, 0, 0, "R2 sub no borrow");
        drive(2, 'h03, 'h05, 1, 1, "R2 sub borrow");
        drive(2, 'h80, 'h01, 0, 0, "R4 sub overflow");
        drive(2, 'h10, 'h01, 0, 0, "R3 nibble borrow only");
        drive(2, 'h42, 'h42, 0, 0, "R5 sub equal");
        drive(3, 'h10, 'h05, 0, 0, "R2 sbc borrow in");
        drive(3, 'h10, 'h05, 1, 0, "R2 sbc no borrow in");
        // R10 decimal adjust edges.
        drive(4, 'h09, 0, 0, 0, "R10 low nibble nine");
        drive(4, 'h0A, 0, 0, 0, "R10 low nibble ten");
        drive(4, 'h99, 0, 0, 0, "R10 at 99");
        drive(4, 'h9A, 0, 0, 0, "R10 at 9A");
        drive(4, 'h12, 0, 1, 1, "R10 flags in");
        // R6 logic, R7/R8 rotates, R9 inc/dec.
        drive(5, 'hF0, 'h0F, 1, 1, "R6 and to zero");
        drive(8, 'hFF, 0, 0, 1, "R6 cpl to zero");
        drive(9, 'h81, 0, 1, 0, "R7 rl");
        drive(10, 'h81, 0, 0, 1, "R7 rr");
        drive(11, 'h80, 0, 0, 0, "R8 rlc out");
        drive(12, 'h01, 0, 1, 0, "R8 rrc out");
        drive(13, 'hFF, 0, 0, 0, "R9 inc wrap");
        drive(14, 'h00, 0, 1, 1, "R9 dec wrap");
        // R11 skip tests.
        drive(15, 0, 0, 0, 0, "R11 sz zero");
        drive(16, 0, 0, 0, 0, "R11 snz zero");
        drive(16, 5, 0, 0, 0, "R11 snz nonzero");
        drive(17, 'hFF, 0, 0, 0, "R11 siz to zero");
        drive(18, 'h02, 0, 0, 0, "R11 sdz not zero");
        drive(18, 'h01, 0, 0, 0, "R11 sdz to zero");
        // Sweep every code with pseudo-random operands and flags.
        for (int o = 0; o < 32; o++) begin
            for (int k = 0; k < 150; k++) begin
                int x, y, ci, aci;
                x = int'($urandom_range(255));
                y = int'($urandom_range(255));
                ci = int'($urandom_range(1));
                aci = int'($urandom_range(1));
                drive(o, x, y, ci, aci, tag_of(o));
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule